// File: doc/BRIEF.md
# Latching Prioritized Interrupt Controller

This block gathers a set of interrupt request inputs and arbitrates among them for one CPU. Each channel has a control register that holds a 3-bit priority level, an enable bit and a request latch. The latch captures a rising edge on the channel input whether or not the channel is enabled. It then stays set until software clears it. Software reaches the registers through a simple write port and a combinational read port.

A single write to a channel always loads its level and enable fields. A detect bit in the written data chooses whether the same write also loads the request latch. With detect clear, the latch is left alone. With detect set, the request bit in the data is written into the latch. So one write can acknowledge an event, raise a software interrupt, or simply mask or unmask the channel.

The arbiter looks at every channel whose latch and enable are both set and whose level is numerically below the CPU's current mask level. Among those it picks the one with the lowest level, and the lowest index breaks ties. It reports the winner as index times four, along with an interrupt line. Both outputs are registered.

Top module: `latch_prio_intc`

## Requirements
- R1: After reset every channel reads back level 7, enable 0 and request 0, and `irq_out` and `grp_num` are 0.
- R2: A rising edge on `irq_in[i]` sets channel i's request latch, whether or not its enable bit is set.
- R3: A set request latch stays set after the input falls, until a write clears it.
- R4: A write with detect (data bit 0) = 1 and request (data bit 1) = 0 clears the channel's request latch (acknowledge).
- R5: A write with detect = 1 and request = 1 sets the channel's request latch (software trigger).
- R6: Every write loads the level field from data bits [6:4] and the enable bit from data bit 2. A write with detect = 0 leaves the request latch unchanged. Read data is {0, level[2:0], 0, enable, request, 0}.
- R7: A channel qualifies only when its request latch and its enable bit are both 1 and its level is strictly less than `cpu_mask`.
- R8: Among qualifying channels the lowest level wins, and a tie goes to the lowest index. `grp_num` carries the winning index shifted left by two.
- R9: When no channel qualifies, `irq_out` is 0 and `grp_num` is 0.
- R10: When an input rising edge and a clearing write hit the same channel in the same cycle, the latch ends up set.
- R11: `irq_out` and `grp_num` reflect the register state and `cpu_mask` of the previous cycle, so they change one clock after a latch, mask or field change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_CH | Per-channel request inputs, latched on rising edge |
| cpu_mask | input | 3 | CPU interrupt mask level; a channel needs a level below this |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | IDX_W | Channel addressed by the write |
| wr_data | input | 8 | Write data: [6:4] level, [2] enable, [1] request, [0] detect |
| rd_ch | input | IDX_W | Channel addressed by the read |
| rd_data | output | 8 | Control register of channel `rd_ch` |
| irq_out | output | 1 | Interrupt to the CPU, high when a channel qualifies |
| grp_num | output | IDX_W+2 | Winning channel index times four, 0 when none qualifies |

## Verification
The hardest case to reach is an input edge and an acknowledge write landing on the same channel in the same clock. The bench drives both in one cycle on purpose, and it does this beside a channel that is disabled but latched. A random phase then mixes writes that have detect set and cleared, input pulses and mask changes. A behavioural model checks every clock, which covers cases such as a tie at the same level, a retrigger while a channel is masked, and a level equal to the mask.

// File: rtl/lpic_pkg.sv
package lpic_pkg;
   localparam int LVL_W    = 3;
   localparam int REG_W    = 8;
   localparam int LVL_LSB  = 4;
   localparam int EN_BIT   = 2;
   localparam int REQ_BIT  = 1;
   localparam int DET_BIT  = 0;
   localparam logic [LVL_W-1:0] LVL_RESET = '1;

   typedef logic [LVL_W-1:0] lvl_t;

   function automatic logic [REG_W-1:0] pack_reg(lvl_t lvl, logic en, logic req);
      logic [REG_W-1:0] r;
      r = '0;
      r[LVL_LSB +: LVL_W] = lvl;
      r[EN_BIT]           = en;
      r[REQ_BIT]          = req;
      return r;
   endfunction
endpackage

// File: rtl/lpic_channel.sv
module lpic_channel
   import lpic_pkg::*;
#(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_in,
   input  logic             wr_sel,
   input  logic [REG_W-1:0] wr_data,
   output lvl_t             lvl_q,
   output logic             en_q,
   output logic             req_q
);
   logic evt;

   generate
      if (EDGE_MODE) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= irq_in;
         end
         assign evt = irq_in & ~prev_q;
      end else begin : g_level
         assign evt = irq_in;
      end
   endgenerate

   logic clr_wr;
   assign clr_wr = wr_sel & wr_data[DET_BIT] & ~wr_data[REQ_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= LVL_RESET;
         en_q  <= 1'b0;
         req_q <= 1'b0;
      end else begin
         if (wr_sel) begin
            lvl_q <= wr_data[LVL_LSB +: LVL_W];
            en_q  <= wr_data[EN_BIT];
            if (wr_data[DET_BIT]) req_q <= wr_data[REQ_BIT];
         end
         if (evt) req_q <= 1'b1;
      end
   end

   // R2
   evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> req_q);

   // R3
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && !clr_wr) |=> req_q);

   // R6
   nodet_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel && !wr_data[DET_BIT] && !evt) |=> $stable(req_q));

   // R4
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !evt) |=> !req_q);
endmodule

// File: rtl/lpic_arbiter.sv
module lpic_arbiter
   import lpic_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  lvl_t [NUM_CH-1:0] lvl,
   input  logic [NUM_CH-1:0] en,
   input  logic [NUM_CH-1:0] req,
   input  lvl_t              mask,
   output logic              found,
   output logic [IDX_W-1:0]  idx
);
   logic [NUM_CH-1:0] cand;

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_cand
         assign cand[g] = req[g] & en[g] & (lvl[g] < mask);
      end
   endgenerate

   always_comb begin
      lvl_t best;
      found = 1'b0;
      idx   = '0;
      best  = '1;
      for (int i = 0; i < NUM_CH; i++) begin
         if (cand[i] && (!found || lvl[i] < best)) begin
            found = 1'b1;
            idx   = IDX_W'(i);
            best  = lvl[i];
         end
      end
   end
endmodule

// File: rtl/latch_prio_intc.sv
module latch_prio_intc
   import lpic_pkg::*;
#(
   parameter int NUM_CH    = 8,
   parameter int IDX_SHIFT = 2,
   parameter bit EDGE_MODE = 1'b1,
   localparam int IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int GRP_W    = IDX_W + IDX_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] irq_in,
   input  logic [LVL_W-1:0]  cpu_mask,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_ch,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [IDX_W-1:0]  rd_ch,
   output logic [REG_W-1:0]  rd_data,
   output logic              irq_out,
   output logic [GRP_W-1:0]  grp_num
);
   initial begin : param_chk
      assert (NUM_CH >= 2 && NUM_CH <= 64) else $error("NUM_CH out of range");
      assert (IDX_SHIFT >= 0 && IDX_SHIFT <= 4) else $error("IDX_SHIFT out of range");
   end

   lvl_t [NUM_CH-1:0] lvl_v;
   logic [NUM_CH-1:0] en_v;
   logic [NUM_CH-1:0] req_v;

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         lpic_channel #(.EDGE_MODE(EDGE_MODE)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .irq_in  (irq_in[g]),
            .wr_sel  (wr_en && (wr_ch == IDX_W'(g))),
            .wr_data (wr_data),
            .lvl_q   (lvl_v[g]),
            .en_q    (en_v[g]),
            .req_q   (req_v[g])
         );
      end
   endgenerate

   logic             win_found;
   logic [IDX_W-1:0] win_idx;

   lpic_arbiter #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_arb (
      .lvl   (lvl_v),
      .en    (en_v),
      .req   (req_v),
      .mask  (cpu_mask),
      .found (win_found),
      .idx   (win_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_out <= 1'b0;
         grp_num <= '0;
      end else begin
         irq_out <= win_found;
         grp_num <= win_found ? GRP_W'({win_idx, {IDX_SHIFT{1'b0}}}) : '0;
      end
   end

   always_comb begin
      rd_data = '0;
      if (32'(rd_ch) < NUM_CH) rd_data = pack_reg(lvl_v[rd_ch], en_v[rd_ch], req_v[rd_ch]);
   end

   // R9
   idle_grp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_out |-> (grp_num == '0));

   // R11
   irq_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> $past(|(req_v & en_v)));
endmodule

// File: tb/latch_prio_intc_tb.sv
module latch_prio_intc_tb;
   localparam int NCH = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] irq_in = '0;
   logic [2:0]     cpu_mask = 3'd7;
   logic           wr_en = 1'b0;
   logic [2:0]     wr_ch = '0;
   logic [7:0]     wr_data = '0;
   logic [2:0]     rd_ch = '0;
   logic [7:0]     rd_data;
   logic           irq_out;
   logic [4:0]     grp_num;

   always #10 clk = ~clk;

   latch_prio_intc u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cpu_mask(cpu_mask),
      .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data), .rd_ch(rd_ch),
      .rd_data(rd_data), .irq_out(irq_out), .grp_num(grp_num)
   );

   int    checks = 0;
   int    failures = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   int m_lvl[NCH];
   bit m_en[NCH], m_req[NCH], m_prev[NCH];
   bit m_irq;
   int m_grp;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            m_lvl[i] = 7; m_en[i] = 0; m_req[i] = 0; m_prev[i] = 0;
         end
         m_irq = 0; m_grp = 0;
      end else begin
         int best, bi;
         best = 99; bi = -1;
         for (int i = 0; i < NCH; i++)
            if (m_req[i] && m_en[i] && m_lvl[i] < int'(cpu_mask) && m_lvl[i] < best) begin
               best = m_lvl[i]; bi = i;
            end
         m_irq = (bi >= 0);
         m_grp = (bi >= 0) ? bi * 4 : 0;
         for (int i = 0; i < NCH; i++) begin
            bit ev;
            ev = irq_in[i] && !m_prev[i];
            if (wr_en && int'(wr_ch) == i) begin
               m_lvl[i] = int'(wr_data[6:4]);
               m_en[i]  = wr_data[2];
               if (wr_data[0]) m_req[i] = wr_data[1];
            end
            if (ev) m_req[i] = 1;
            m_prev[i] = irq_in[i];
         end
      end
   end

   task automatic chk(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         int e;
         e = (m_lvl[rd_ch] << 4) | (int'(m_en[rd_ch]) << 2) | (int'(m_req[rd_ch]) << 1);
         chk("irq_out", int'(irq_out), int'(m_irq));
         chk("grp_num", int'(grp_num), m_grp);
         chk("rd_data", int'(rd_data), e);
      end
   end

   function automatic logic [7:0] mk(int lvl, bit en, bit req, bit det);
      return {1'b0, 3'(lvl), 1'b0, en, req, det};
   endfunction

   task automatic step();
      @(negedge clk); #2;
   endtask

   task automatic do_write(int ch, logic [7:0] d);
      wr_en = 1'b1; wr_ch = 3'(ch); wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic pulse(int ch);
      irq_in[ch] = 1'b1;
      step();
      irq_in[ch] = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) step();
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         failures++;
         $display("FAIL R11 watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #2 rst_n = 1'b1;
      // R1: reset values of every channel
      cur_req = "R1";
      for (int i = 0; i < NCH; i++) begin
         rd_ch = 3'(i); step();
      end
      // R2: latch while disabled, no irq
      cur_req = "R2";
      rd_ch = 3'd3;
      pulse(3); idle(2);
      // R3: latch held after input low
      cur_req = "R3";
      irq_in[3] = 1'b1; idle(3); irq_in[3] = 1'b0; idle(3);
      // R7: qualification against mask
      cur_req = "R7";
      do_write(3, mk(2, 1, 0, 0)); idle(2);
      cpu_mask = 3'd2; idle(2);
      cpu_mask = 3'd3; idle(2);
      cpu_mask = 3'd7;
      // R8: priority and tie breaking
      cur_req = "R8";
      do_write(5, mk(1, 1, 0, 0)); rd_ch = 3'd5; pulse(5); idle(2);
      do_write(1, mk(1, 1, 0, 0)); rd_ch = 3'd1; pulse(1); idle(2);
      // R4: acknowledge
      cur_req = "R4";
      do_write(1, mk(1, 1, 0, 1)); idle(2);
      // R5: software trigger
      cur_req = "R5";
      rd_ch = 3'd6;
      do_write(6, mk(0, 1, 1, 1)); idle(2);
      // R6: no detect leaves latch, fields update
      cur_req = "R6";
      rd_ch = 3'd0;
      do_write(0, mk(0, 1, 1, 0)); idle(2);
      rd_ch = 3'd6;
      do_write(6, mk(4, 0, 0, 0)); idle(2);
      // R10: edge and ack in same cycle
      cur_req = "R10";
      rd_ch = 3'd2;
      do_write(2, mk(0, 1, 0, 0));
      irq_in[2] = 1'b1; wr_en = 1'b1; wr_ch = 3'd2; wr_data = mk(0, 1, 0, 1);
      step();
      irq_in[2] = 1'b0; wr_en = 1'b0; idle(2);
      // R11: output one cycle after a change
      cur_req = "R11";
      do_write(2, mk(0, 0, 0, 0)); idle(1);
      cpu_mask = 3'd0; idle(1); cpu_mask = 3'd7; idle(1);
      // R9: clear everything
      cur_req = "R9";
      for (int i = 0; i < NCH; i++) do_write(i, mk(3, 1, 0, 1));
      idle(3);
      // R8: random mix
      cur_req = "R8";
      for (int n = 0; n < 3000; n++) begin
         irq_in = NCH'($urandom);
         wr_en = ($urandom % 3) == 0;
         wr_ch = 3'($urandom);
         wr_data = mk(int'($urandom % 8), 1'($urandom), 1'($urandom), 1'($urandom));
         rd_ch = 3'($urandom);
         if (($urandom % 8) == 0) cpu_mask = 3'($urandom);
         step();
      end
      wr_en = 1'b0; irq_in = '0; idle(3);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule